// File: doc/BRIEF.md
# Matmul Accumulator Group Controller

This block sits between the command stream of a matrix-multiply engine and the accumulator memory that the engine writes into. It takes one command at a time. Each command carries a column-group mask, a row-group mask, a bus select, the active column and row counts, the begin/end accumulate flags, a zero-region code and the destination byte offset inside a partition. The block checks the command for legality. If the command is illegal, it raises a one-cycle error and writes nothing. If the command is legal, it emits a short stream of bank-write beats, one per accumulator bank the command covers.

Each beat gives four things: the destination partition base, the source partition base, the bank index, and the zero-before-accumulate bank mask. It also says whether the bank is overwritten or read-modify-written. Across a multi-tile reduction loop, the block remembers which banks hold an open accumulation group. A middle or closing tile that lands on a bank with no open group is refused.

Top module: `mm_accum_ctrl`

## Requirements
- R1: After reset the command input is ready, no beat is offered and the error output is low.
- R2: Column mask 0xF gives destination partition 0, allows up to 128 columns and needs bus select 0x10. Mask 0x3 gives partition 0 and mask 0xC gives partition 64; both allow up to 64 columns, with bus selects 0x01 and 0x04. Masks 0x1, 0x2 and 0x4 give partitions 0, 32 and 64, allow up to 32 columns, with bus selects 0x01, 0x02 and 0x04. A column count above the limit, a wrong bus select, or any other mask is an error.
- R3: Column mask 0x8 on its own is always rejected, whatever bus select, column count or row count comes with it.
- R4: Row mask 0xF, 0x3 or 0x1 gives source partition 0. Mask 0x2 gives 32, mask 0xC or 0x4 gives 64, and mask 0x8 gives 96. Any other row mask is an error.
- R5: The flags byte must be 0 to 3. Active rows must be 1 to 128, and active columns at least 1. Anything else is an error.
- R6: The bank index is the destination offset divided by 2048; offset bits 13:11 give banks 0 to 7. Zero-region code z covers 2^z consecutive banks starting at that index, and a span that passes bank 7 is an error. A legal command emits one beat per covered bank, in ascending bank order, with a last marker on the final beat.
- R7: Flag bit 0 (start) makes every beat an overwrite carrying the covered banks in the zero mask, and opens a group on those banks. A start on an already open bank re-zeroes it and keeps it open.
- R8: Flags 0 (middle) and 2 (end) make read-modify-write beats with an empty zero mask. They are an error unless every covered bank has an open group.
- R9: Flag bit 1 (end) sets the drain marker on every beat and closes the covered banks. Flags 3 (single) overwrite, zero, drain and leave the banks closed.
- R10: With the zero-size parameter cleared, only zero-region code 0 is legal.
- R11: While beats are pending, no new command is taken. A beat that is offered stays unchanged until the write side accepts it.
- R12: An illegal command is consumed with a one-cycle error pulse. It emits no beat and leaves the open-group state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_col_grp | input | 4 | Column-group mask |
| cmd_row_grp | input | 4 | Row-group mask |
| cmd_bus | input | 8 | Bus select code |
| cmd_cols | input | 8 | Active column count |
| cmd_rows | input | 8 | Active row count |
| cmd_flags | input | 8 | Accumulate flags (bit 0 start, bit 1 end) |
| cmd_zone | input | 2 | Zero-region code |
| cmd_off | input | 14 | Destination byte offset within a partition |
| wr_valid | output | 1 | Bank-write beat offered |
| wr_ready | input | 1 | Write side accepts the beat |
| wr_part | output | 7 | Destination partition base |
| wr_src | output | 7 | Source partition base |
| wr_bank | output | 3 | Bank index of this beat |
| wr_zmask | output | 8 | Banks to zero before accumulation |
| wr_rmw | output | 1 | 1 = read-modify-write, 0 = overwrite |
| wr_last | output | 1 | Final beat of the command |
| wr_drain | output | 1 | Group ends with this command |
| err | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hardest state to reach is a middle or closing tile whose span only partly overlaps an open group. For example, a group opened over two banks followed by a four-bank accumulate, or a closing tile after a re-opened start. In both cases the refusal depends on history rather than on the command itself.

The stimulus builds these histories deliberately. It opens groups with start tiles of different widths, re-starts one of them, closes part of the range, and then aims middle and end tiles at the edges. Random stalls on the write side run at the same time, so acceptance timing is also stressed while groups are open.

// File: rtl/mm_accum_ctrl.sv
module mm_accum_ctrl #(
  parameter int PARTS      = 128,
  parameter int BANKS      = 8,
  parameter int BANK_BYTES = 2048,
  parameter int MAX_ROWS   = 128,
  parameter bit WIDE_ZONES = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  output logic                                   cmd_ready,
  input  logic [3:0]                             cmd_col_grp,
  input  logic [3:0]                             cmd_row_grp,
  input  logic [7:0]                             cmd_bus,
  input  logic [$clog2(PARTS):0]                 cmd_cols,
  input  logic [$clog2(PARTS):0]                 cmd_rows,
  input  logic [7:0]                             cmd_flags,
  input  logic [1:0]                             cmd_zone,
  input  logic [$clog2(BANKS*BANK_BYTES)-1:0]    cmd_off,
  output logic                                   wr_valid,
  input  logic                                   wr_ready,
  output logic [$clog2(PARTS)-1:0]               wr_part,
  output logic [$clog2(PARTS)-1:0]               wr_src,
  output logic [$clog2(BANKS)-1:0]               wr_bank,
  output logic [BANKS-1:0]                       wr_zmask,
  output logic                                   wr_rmw,
  output logic                                   wr_last,
  output logic                                   wr_drain,
  output logic                                   err
);
  localparam int PW = $clog2(PARTS);
  localparam int BW = $clog2(BANKS);
  localparam int OW = $clog2(BANKS*BANK_BYTES);
  localparam int CW = PW + 1;
  localparam int QP = PARTS / 4;

  logic          busy, err_q, rmw_q, drain_q;
  logic [BW-1:0] cnt, base_q;
  logic [BW:0]   span_q;
  logic [PW-1:0] part_q, src_q;
  logic [BANKS-1:0] zm_q, open_q;

  logic [PW-1:0] dst, src;
  logic [CW-1:0] lim;
  logic [7:0]    need_bus;
  logic          col_ok, row_ok;

  always_comb begin
    dst = '0; lim = '0; need_bus = 8'h00; col_ok = 1'b1;
    case (cmd_col_grp)
      4'hF: begin lim = CW'(PARTS);   need_bus = 8'h10; end
      4'h3: begin lim = CW'(PARTS/2); need_bus = 8'h01; end
      4'hC: begin dst = PW'(PARTS/2); lim = CW'(PARTS/2); need_bus = 8'h04; end
      4'h1: begin lim = CW'(QP); need_bus = 8'h01; end
      4'h2: begin dst = PW'(QP);   lim = CW'(QP); need_bus = 8'h02; end
      4'h4: begin dst = PW'(2*QP); lim = CW'(QP); need_bus = 8'h04; end
      default: col_ok = 1'b0;
    endcase
  end

  always_comb begin
    src = '0; row_ok = 1'b1;
    case (cmd_row_grp)
      4'hF, 4'h3, 4'h1: src = '0;
      4'h2:             src = PW'(QP);
      4'hC, 4'h4:       src = PW'(2*QP);
      4'h8:             src = PW'(3*QP);
      default:          row_ok = 1'b0;
    endcase
  end

  wire [BW-1:0] bank  = cmd_off[OW-1:OW-BW];
  wire [BW:0]   span  = (BW+1)'(1) << cmd_zone;
  wire          start = cmd_flags[0];
  wire          fin   = cmd_flags[1];
  wire [2*BANKS-1:0] wide =
    (((2*BANKS)'(1) << span) - (2*BANKS)'(1)) << bank;
  wire [BANKS-1:0] smask = wide[BANKS-1:0];

  wire span_ok  = ({1'b0, bank} + span) <= (BW+1)'(BANKS);
  wire zone_ok  = WIDE_ZONES || (cmd_zone == 2'd0);
  wire open_ok  = start || ((open_q & smask) == smask);
  wire shape_ok = (cmd_flags[7:2] == 6'd0) && (cmd_rows != '0) &&
                  (cmd_rows <= CW'(MAX_ROWS)) && (cmd_cols != '0) && (cmd_cols <= lim);
  wire legal    = col_ok && (cmd_bus == need_bus) && row_ok && shape_ok &&
                  zone_ok && span_ok && open_ok;
  wire accept   = cmd_valid && !busy;
  wire beat_go  = busy && wr_ready;

  assign cmd_ready = !busy;
  assign wr_valid  = busy;
  assign wr_part   = part_q;
  assign wr_src    = src_q;
  assign wr_bank   = base_q + cnt;
  assign wr_zmask  = zm_q;
  assign wr_rmw    = rmw_q;
  assign wr_drain  = drain_q;
  assign wr_last   = ({1'b0, cnt} + 1'b1) == span_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; err_q <= 1'b0; cnt <= '0; base_q <= '0; span_q <= '0;
      part_q <= '0; src_q <= '0; zm_q <= '0; rmw_q <= 1'b0; drain_q <= 1'b0;
      open_q <= '0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) begin
        busy    <= 1'b1;
        cnt     <= '0;
        base_q  <= bank;
        span_q  <= span;
        part_q  <= dst;
        src_q   <= src;
        zm_q    <= start ? smask : '0;
        rmw_q   <= !start;
        drain_q <= fin;
        if (fin)        open_q <= open_q & ~smask;
        else if (start) open_q <= open_q | smask;
      end else if (beat_go) begin
        if (wr_last) busy <= 1'b0;
        else         cnt  <= cnt + 1'b1;
      end
    end
  end

  a_r11_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_bank) && $stable(wr_part) &&
                              $stable(wr_zmask) && $stable(wr_rmw));
  a_r6_beats_continue: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_last |=> wr_valid);
  a_r12_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_valid);
  a_r3_no_q3_dest: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_part != PW'(3*QP));
  a_r7_zero_covers_bank: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_zmask != '0) |-> wr_zmask[wr_bank]);
  a_r8_mode_matches_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_rmw == (wr_zmask == '0)));
endmodule

// File: tb/mm_accum_ctrl_bench.sv
module mm_accum_ctrl_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       cmd_valid = 0, n_valid = 0, wr_ready = 1;
  logic [3:0] cmd_col = 0, cmd_row = 0;
  logic [7:0] cmd_bus = 0, cmd_cols = 0, cmd_rows = 0, cmd_flags = 0;
  logic [1:0] cmd_zone = 0;
  logic [13:0] cmd_off = 0;

  logic cmd_ready, wr_valid, wr_rmw, wr_last, wr_drain, err;
  logic [6:0] wr_part, wr_src;
  logic [2:0] wr_bank;
  logic [7:0] wr_zmask;

  logic n_ready, n_wvalid, n_rmw, n_last, n_drain, n_err;
  logic [6:0] n_part, n_src;
  logic [2:0] n_bank;
  logic [7:0] n_zmask;

  mm_accum_ctrl u_mm_accum_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_col_grp(cmd_col), .cmd_row_grp(cmd_row), .cmd_bus(cmd_bus),
    .cmd_cols(cmd_cols), .cmd_rows(cmd_rows), .cmd_flags(cmd_flags),
    .cmd_zone(cmd_zone), .cmd_off(cmd_off), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_part(wr_part), .wr_src(wr_src), .wr_bank(wr_bank), .wr_zmask(wr_zmask),
    .wr_rmw(wr_rmw), .wr_last(wr_last), .wr_drain(wr_drain), .err(err));

  mm_accum_ctrl #(.WIDE_ZONES(1'b0)) u_narrow (
    .clk(clk), .rst_n(rst_n), .cmd_valid(n_valid), .cmd_ready(n_ready),
    .cmd_col_grp(cmd_col), .cmd_row_grp(cmd_row), .cmd_bus(cmd_bus),
    .cmd_cols(cmd_cols), .cmd_rows(cmd_rows), .cmd_flags(cmd_flags),
    .cmd_zone(cmd_zone), .cmd_off(cmd_off), .wr_valid(n_wvalid), .wr_ready(1'b1),
    .wr_part(n_part), .wr_src(n_src), .wr_bank(n_bank), .wr_zmask(n_zmask),
    .wr_rmw(n_rmw), .wr_last(n_last), .wr_drain(n_drain), .err(n_err));

  int total = 0, bad = 0;
  bit stall = 0;
  logic [27:0] q[$];
  bit [7:0] m_open = 0;
  bit m_err = 0, m_acc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_accept();
    int dst, lim, need, src, span, bank;
    bit cok, rok, st, fn, legal;
    bit [7:0] sm;
    dst = 0; lim = 0; need = -1; src = 0; cok = 1; rok = 1;
    case (cmd_col)
      4'hF: begin lim = 128; need = 'h10; end
      4'h3: begin lim = 64;  need = 'h01; end
      4'hC: begin dst = 64; lim = 64; need = 'h04; end
      4'h1: begin lim = 32;  need = 'h01; end
      4'h2: begin dst = 32; lim = 32; need = 'h02; end
      4'h4: begin dst = 64; lim = 32; need = 'h04; end
      default: cok = 0;   // includes lone 0x8 (R3)
    endcase
    case (cmd_row)
      4'hF, 4'h3, 4'h1: src = 0;
      4'h2: src = 32;
      4'hC, 4'h4: src = 64;
      4'h8: src = 96;
      default: rok = 0;
    endcase
    span = 1 << cmd_zone;
    bank = int'(cmd_off) / 2048;
    sm = 0;
    for (int i = 0; i < span; i++) if (bank + i < 8) sm[bank+i] = 1'b1;
    st = cmd_flags[0]; fn = cmd_flags[1];
    legal = cok && (int'(cmd_bus) == need) && rok && cmd_flags <= 3 &&
            cmd_rows >= 1 && cmd_rows <= 128 && cmd_cols >= 1 && int'(cmd_cols) <= lim &&
            bank + span <= 8 && (st || (m_open & sm) == sm);
    if (!legal) m_err = 1;
    else begin
      for (int i = 0; i < span; i++)
        q.push_back({7'(dst), 7'(src), 3'(bank + i), (st ? sm : 8'h00), ~st,
                     1'(i == span - 1), fn});
      if (fn) m_open &= ~sm;
      else if (st) m_open |= sm;
    end
  endtask

  task automatic compare();
    logic [27:0] h;
    chk("R11 cmd_ready", 32'(cmd_ready), 32'(q.size() == 0));
    chk("R11 wr_valid", 32'(wr_valid), 32'(q.size() > 0));
    chk("R12 err", 32'(err), 32'(m_err));
    if (q.size() > 0 && wr_valid) begin
      h = q[0];
      chk("R2 wr_part", 32'(wr_part), 32'(h[27:21]));
      chk("R4 wr_src", 32'(wr_src), 32'(h[20:14]));
      chk("R6 wr_bank", 32'(wr_bank), 32'(h[13:11]));
      chk("R7 wr_zmask", 32'(wr_zmask), 32'(h[10:3]));
      chk("R8 wr_rmw", 32'(wr_rmw), 32'(h[2]));
      chk("R6 wr_last", 32'(wr_last), 32'(h[1]));
      chk("R9 wr_drain", 32'(wr_drain), 32'(h[0]));
    end
  endtask

  task automatic step();
    bit was_busy;
    wr_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
    was_busy = q.size() > 0;
    m_err = 0; m_acc = 0;
    if (was_busy && wr_ready) void'(q.pop_front());
    if (!was_busy && cmd_valid) begin m_acc = 1; m_accept(); end
    @(negedge clk);
    compare();
  endtask

  task automatic send(logic [3:0] c, logic [3:0] r, logic [7:0] b, logic [7:0] cols,
                      logic [7:0] rows, logic [7:0] f, logic [1:0] z, logic [13:0] off);
    cmd_col = c; cmd_row = r; cmd_bus = b; cmd_cols = cols; cmd_rows = rows;
    cmd_flags = f; cmd_zone = z; cmd_off = off; cmd_valid = 1;
    do step(); while (!m_acc);
    cmd_valid = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
    step();
  endtask

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 valid", 32'(wr_valid), 0);
    chk("R1 err", 32'(err), 0);
    rst_n = 1;
    step();

    // R2 column masks at their limits, single tiles
    send(4'hF, 4'hF, 8'h10, 128, 128, 3, 0, 0);      drain();
    send(4'h3, 4'hF, 8'h01, 64, 1, 3, 0, 14'd2048);  drain();
    send(4'hC, 4'hF, 8'h04, 64, 1, 3, 0, 0);         drain();
    send(4'h1, 4'hF, 8'h01, 32, 1, 3, 0, 0);         drain();
    send(4'h2, 4'hF, 8'h02, 32, 1, 3, 0, 0);         drain();
    send(4'h4, 4'hF, 8'h04, 32, 1, 3, 0, 0);         drain();
    send(4'h2, 4'hF, 8'h02, 33, 1, 3, 0, 0);  chk("R2 cols over limit", 32'(err), 1); drain();
    send(4'hF, 4'hF, 8'h01, 8, 1, 3, 0, 0);   chk("R2 wrong bus", 32'(err), 1); drain();
    send(4'h6, 4'hF, 8'h04, 8, 1, 3, 0, 0);   chk("R2 odd mask", 32'(err), 1); drain();

    // R3 lone quadrant-3 mask
    send(4'h8, 4'hF, 8'h08, 32, 1, 3, 0, 0);  chk("R3 lone q3", 32'(err), 1); drain();
    send(4'h8, 4'h8, 8'h00, 1, 1, 3, 0, 0);   chk("R3 lone q3 bus0", 32'(err), 1); drain();

    // R4 row masks
    send(4'hF, 4'h2, 8'h10, 4, 1, 3, 0, 0);   drain();
    send(4'hF, 4'hC, 8'h10, 4, 1, 3, 0, 0);   drain();
    send(4'hF, 4'h4, 8'h10, 4, 1, 3, 0, 0);   drain();
    send(4'hF, 4'h8, 8'h10, 4, 1, 3, 0, 0);   drain();
    send(4'hF, 4'h3, 8'h10, 4, 1, 3, 0, 0);   drain();
    send(4'hF, 4'h5, 8'h10, 4, 1, 3, 0, 0);   chk("R4 bad row mask", 32'(err), 1); drain();

    // R5 flag and count ranges
    send(4'hF, 4'hF, 8'h10, 4, 1, 4, 0, 0);   chk("R5 flags 4", 32'(err), 1); drain();
    send(4'hF, 4'hF, 8'h10, 4, 0, 3, 0, 0);   chk("R5 rows 0", 32'(err), 1); drain();
    send(4'hF, 4'hF, 8'h10, 4, 129, 3, 0, 0); chk("R5 rows 129", 32'(err), 1); drain();
    send(4'hF, 4'hF, 8'h10, 0, 1, 3, 0, 0);   chk("R5 cols 0", 32'(err), 1); drain();

    // R6 spans, R11 under stalls
    stall = 1;
    send(4'hF, 4'hF, 8'h10, 16, 16, 3, 3, 14'd100); drain();
    send(4'hF, 4'hF, 8'h10, 16, 16, 3, 2, 14'd8192); drain();
    send(4'hF, 4'hF, 8'h10, 16, 16, 3, 1, 14'd12300); drain();
    send(4'hF, 4'hF, 8'h10, 16, 16, 3, 2, 14'd10240); chk("R6 span past bank 7", 32'(err), 1); drain();

    // R7 R8 R9 reduction loop on banks 2..3
    send(4'h1, 4'h1, 8'h01, 8, 64, 1, 1, 14'd4096); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 0, 1, 14'd4096); chk("R8 mid accepted", 32'(err), 0); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 1, 0, 14'd6144); drain();   // R7 re-start bank 3
    send(4'h1, 4'h1, 8'h01, 8, 64, 0, 2, 14'd4096); chk("R8 partial overlap", 32'(err), 1); drain();
    // R12 illegal command leaves groups open
    send(4'h1, 4'h1, 8'h01, 8, 64, 8, 1, 14'd4096); chk("R12 err pulse", 32'(err), 1);
    step(); chk("R12 pulse single", 32'(err), 0);
    send(4'h1, 4'h1, 8'h01, 8, 64, 2, 1, 14'd4096); chk("R9 end accepted", 32'(err), 0); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 0, 0, 14'd4096); chk("R9 closed after end", 32'(err), 1); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 2, 0, 14'd14336); chk("R8 end never opened", 32'(err), 1); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 1, 0, 14'd0); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 3, 0, 14'd0); drain();
    send(4'h1, 4'h1, 8'h01, 8, 64, 0, 0, 14'd0); chk("R9 single closes", 32'(err), 1); drain();
    stall = 0;

    // R10 narrow generation: only zone 0
    cmd_col = 4'hF; cmd_row = 4'hF; cmd_bus = 8'h10; cmd_cols = 1; cmd_rows = 1;
    cmd_flags = 3; cmd_zone = 1; cmd_off = 0; n_valid = 1;
    step(); n_valid = 0;
    chk("R10 zone1 rejected", 32'(n_err), 1);
    chk("R10 no beat", 32'(n_wvalid), 0);
    cmd_zone = 0; n_valid = 1;
    step(); n_valid = 0;
    chk("R10 zone0 beat", 32'(n_wvalid), 1);
    chk("R10 zone0 mask", 32'(n_zmask), 1);
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule